// File: doc/BRIEF.md
# Serial CAN Frame Check Sequence Generator

This block builds the 15-bit check sequence of a CAN frame one bit per clock. The transmitter or receiver feeds it the frame's destuffed bits, from the start-of-frame bit through the last data bit, and raises a valid strobe on each cycle that carries a bit. Stuff bits, delimiters, the acknowledge slot and end-of-frame are never presented. A synchronous clear starts each new frame from zero. The remainder is always visible as a parallel word, with no final inversion and no bit reflection.

The running remainder follows the CAN generator x^15 + x^14 + x^10 + x^8 + x^7 + x^4 + x^3 + 1. Written without its top term, this is the constant 0x4599, with x^0 in the least significant bit. On each valid bit, the feedback is the incoming bit XOR the register's top bit. The register then shifts left, and the constant is XORed in when the feedback is one.

For transmission the same register can shift its contents out serially, most significant bit first. The serial output always shows the bit that is on the line during the current shift cycle.

Top module: `can_crc15_gen`

## Requirements
- R1: On a cycle with `bit_valid_i` high and `clear_i` and `shift_i` low, the register becomes its old value shifted left by one with a zero in bit 0 and masked to 15 bits. When `bit_i` differs from old bit 14, that result is also XORed with 0x4599.
- R2: When `clear_i` is high at a clock edge, the register becomes zero, whatever `shift_i`, `bit_valid_i` and `bit_i` are.
- R3: While `rst_n` is low at a clock edge, the register becomes zero, and `crc_o` reads 0 after reset.
- R4: When `clear_i`, `shift_i` and `bit_valid_i` are all low, the register holds its value, whatever `bit_i` does.
- R5: After a clear, the 47-bit extended frame 0 00100000000 1 1 000001000000010000 0 0 0 0001 00000001, fed first bit first, leaves `crc_o` = 0x4A99.
- R6: When `shift_i` is high and `clear_i` is low, the register shifts left by one with zero fill and no feedback. `ser_o` equals register bit 14 during that cycle, so 15 shifts emit the remainder MSB first and leave zero.
- R7: When `shift_i` and `bit_valid_i` are both high, the data bit is ignored and the plain shift of R6 applies.
- R8: A message followed by its own 15 check bits, MSB first, leaves a zero remainder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clear_i | input | 1 | Start a new frame: zero the remainder |
| bit_valid_i | input | 1 | `bit_i` carries a frame bit this cycle |
| bit_i | input | 1 | Destuffed serial frame bit |
| shift_i | input | 1 | Shift the remainder out serially |
| crc_o | output | 15 | Current remainder, parallel |
| ser_o | output | 1 | Serial readout bit (register bit 14) |

## Verification
The remainder is exercised with several bit patterns:
- A single one shows the plain polynomial injection.
- A one followed by a zero shows feedback when bit 14 is set.
- An all-zero run must stay at zero.
- The 47-bit extended frame with a known check value ties the bit order and polynomial to real frames.

A long alternating pattern is compared against a bit model in the bench. That same message is then followed by its own check bits, which must give zero; this catches errors in the feedback tap or in the serial order. Directed cases pit clear against data, shift against data, and idle cycles against a toggling data pin, to show the control priorities and the hold behaviour.

// File: rtl/can_crc15_pkg.sv
// Package: shared constants and the control-decision type for the
// serial CAN check-sequence generator.
package can_crc15_pkg;

    localparam int          CRC_W_DEF = 15;
    localparam logic [14:0] POLY_DEF  = 15'h4599;

    // Operation selected for the remainder register on one clock edge.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_CLEAR = 2'd1,
        OP_SHIFT = 2'd2,
        OP_FEED  = 2'd3
    } crc_op_e;

endpackage

// File: rtl/can_crc15_ctrl.sv
// Module: can_crc15_ctrl
// Decodes the control inputs into one register operation.
// Priority order: clear, then serial shift, then data feed, then hold.
// Assumes the inputs are synchronous to the register clock.
module can_crc15_ctrl
    import can_crc15_pkg::*;
(
    input  logic    clear_i,
    input  logic    shift_i,
    input  logic    bit_valid_i,
    output crc_op_e op_o
);

    // Priority decode of the control inputs.
    always_comb begin
        if (clear_i)          op_o = OP_CLEAR;
        else if (shift_i)     op_o = OP_SHIFT;
        else if (bit_valid_i) op_o = OP_FEED;
        else                  op_o = OP_HOLD;
    end

endmodule

// File: rtl/can_crc15_step.sv
// Module: can_crc15_step
// Combinational one-bit remainder update. The feedback is the data bit XOR
// the top register bit. The register shifts left, and the polynomial taps
// flip where the feedback is one.
// Assumes POLY holds the generator without its top term, x^0 in bit 0.
module can_crc15_step #(
    parameter int             CRC_W = 15,
    parameter logic [CRC_W-1:0] POLY  = 15'h4599
) (
    input  logic [CRC_W-1:0] cur_i,
    input  logic             din_i,
    output logic [CRC_W-1:0] nxt_o
);

    logic             fb;
    logic [CRC_W-1:0] shifted;

    // Feedback and plain left shift.
    always_comb begin
        fb      = din_i ^ cur_i[CRC_W-1];
        shifted = {cur_i[CRC_W-2:0], 1'b0};
    end

    // One XOR per bit position, used only where the polynomial has a tap.
    for (genvar i = 0; i < CRC_W; i++) begin : g_tap
        if (POLY[i]) begin : g_xor
            assign nxt_o[i] = shifted[i] ^ fb;
        end else begin : g_wire
            assign nxt_o[i] = shifted[i];
        end
    end

endmodule

// File: rtl/can_crc15_reg.sv
// Module: can_crc15_reg
// Remainder storage. Applies the decoded operation on each clock edge.
// Reset is synchronous and active low. Assumes feed_i and shl_i are
// computed from q_o in the same cycle.
module can_crc15_reg
    import can_crc15_pkg::*;
#(
    parameter int CRC_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  crc_op_e          op_i,
    input  logic [CRC_W-1:0] feed_i,
    input  logic [CRC_W-1:0] shl_i,
    output logic [CRC_W-1:0] q_o
);

    // Register update, chosen by the operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= '0;
        end else begin
            unique case (op_i)
                OP_CLEAR: q_o <= '0;
                OP_SHIFT: q_o <= shl_i;
                OP_FEED:  q_o <= feed_i;
                default:  q_o <= q_o;
            endcase
        end
    end

endmodule

// File: rtl/can_crc15_gen.sv
// Module: can_crc15_gen (top)
// Bit-serial CAN check-sequence generator with parallel and MSB-first
// serial readout. Assumes the caller presents only destuffed bits, from
// start-of-frame through the data field, and pulses clear_i before each
// frame.
module can_crc15_gen
    import can_crc15_pkg::*;
#(
    parameter int               CRC_W = CRC_W_DEF,
    parameter logic [CRC_W-1:0] POLY  = POLY_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             bit_valid_i,
    input  logic             bit_i,
    input  logic             shift_i,
    output logic [CRC_W-1:0] crc_o,
    output logic             ser_o
);

    crc_op_e          op;
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] feed_val;
    logic [CRC_W-1:0] shl_val;

    can_crc15_ctrl u_ctrl (
        .clear_i     (clear_i),
        .shift_i     (shift_i),
        .bit_valid_i (bit_valid_i),
        .op_o        (op)
    );

    can_crc15_step #(.CRC_W(CRC_W), .POLY(POLY)) u_step (
        .cur_i (crc_q),
        .din_i (bit_i),
        .nxt_o (feed_val)
    );

    // Zero-fill left shift for the serial readout.
    always_comb shl_val = {crc_q[CRC_W-2:0], 1'b0};

    can_crc15_reg #(.CRC_W(CRC_W)) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .op_i   (op),
        .feed_i (feed_val),
        .shl_i  (shl_val),
        .q_o    (crc_q)
    );

    // Drive the parallel and serial outputs.
    always_comb begin
        crc_o = crc_q;
        ser_o = crc_q[CRC_W-1];
    end

endmodule

// File: rtl/can_crc15_gen_chk.sv
// Module: can_crc15_gen_chk
// Property checker for can_crc15_gen. It observes the ports only and is
// attached by the bind statement at the end of this file.
module can_crc15_gen_chk #(
    parameter int               CRC_W = 15,
    parameter logic [CRC_W-1:0] POLY  = 15'h4599
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clear_i,
    input logic             bit_valid_i,
    input logic             bit_i,
    input logic             shift_i,
    input logic [CRC_W-1:0] crc_o,
    input logic             ser_o
);

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (crc_o == '0)); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !shift_i && !bit_valid_i) |=> $stable(crc_o)); // R4

    AST_SHIFT_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && shift_i) |=> (crc_o == {$past(crc_o[CRC_W-2:0]), 1'b0})); // R6

    AST_FEED_NO_TAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !shift_i && bit_valid_i && (bit_i == crc_o[CRC_W-1]))
        |=> (crc_o == {$past(crc_o[CRC_W-2:0]), 1'b0})); // R1

    AST_FEED_TAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !shift_i && bit_valid_i && (bit_i != crc_o[CRC_W-1]))
        |=> (crc_o == ({$past(crc_o[CRC_W-2:0]), 1'b0} ^ POLY))); // R1

    AST_SER_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i |-> (ser_o == crc_o[CRC_W-1])); // R6

endmodule

bind can_crc15_gen can_crc15_gen_chk #(.CRC_W(CRC_W), .POLY(POLY)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (clear_i),
    .bit_valid_i (bit_valid_i),
    .bit_i       (bit_i),
    .shift_i     (shift_i),
    .crc_o       (crc_o),
    .ser_o       (ser_o)
);

// File: tb/can_crc15_gen_tb_top.sv
// Bench for can_crc15_gen: a vector table walked by one loop, then
// directed tests for reset, priorities, serial readout and the
// self-check property.
module can_crc15_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear_i = 1'b0;
    logic        bit_valid_i = 1'b0;
    logic        bit_i = 1'b0;
    logic        shift_i = 1'b0;
    logic [14:0] crc_o;
    logic        ser_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    can_crc15_gen dut_i (
        .clk (clk), .rst_n (rst_n), .clear_i (clear_i),
        .bit_valid_i (bit_valid_i), .bit_i (bit_i), .shift_i (shift_i),
        .crc_o (crc_o), .ser_o (ser_o)
    );

    typedef struct packed {
        logic [6:0]  len;
        logic [63:0] bits;   // right-aligned, first bit at position len-1
        logic [14:0] exp;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{7'd47, {17'd0, 1'b0, 11'b00100000000, 1'b1, 1'b1,
                  18'b000001000000010000, 3'b000, 4'b0001, 8'b00000001},
          15'h4A99},                                   // R5
        '{7'd1,  64'h1, 15'h4599},                     // R1 single one
        '{7'd2,  64'h2, 15'h4EAB},                     // R1 one then zero
        '{7'd20, 64'h0, 15'h0000}                      // R1 all zeros
    };

    // Independent bit model of the requirement R1.
    function automatic logic [14:0] model_step(logic [14:0] c, logic b);
        logic [14:0] s;
        s = {c[13:0], 1'b0};
        return (b ^ c[14]) ? (s ^ 15'h4599) : s;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Inputs change on the falling edge; results are read on the next one.
    task automatic cycle(logic clr, logic vld, logic b, logic sh);
        @(negedge clk);
        clear_i = clr; bit_valid_i = vld; bit_i = b; shift_i = sh;
        @(negedge clk);
        clear_i = 1'b0; bit_valid_i = 1'b0; shift_i = 1'b0;
    endtask

    task automatic feed(logic [63:0] bits, int len);
        for (int i = len - 1; i >= 0; i--) cycle(1'b0, 1'b1, bits[i], 1'b0);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [14:0] ref_crc;
        logic [14:0] saved;
        logic [14:0] got;
        logic [63:0] pat;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R3 reset value", crc_o, 15'h0);

        // Vector table walk.
        foreach (VECS[k]) begin
            cycle(1'b1, 1'b0, 1'b0, 1'b0);
            feed(VECS[k].bits, int'(VECS[k].len));
            check($sformatf("R1/R5 vector %0d", k), crc_o, VECS[k].exp);
        end

        // R1: long pattern against the bench model.
        pat = 64'hA5C3_0F96_3C5A_E718;
        ref_crc = '0;
        for (int i = 63; i >= 0; i--) ref_crc = model_step(ref_crc, pat[i]);
        cycle(1'b1, 1'b0, 1'b0, 1'b0);
        feed(pat, 64);
        check("R1 long pattern", crc_o, ref_crc);

        // R8: append its own check bits, expect zero.
        feed({49'd0, ref_crc}, 15);
        check("R8 zero residue", crc_o, 15'h0);

        // R4: idle cycles with a toggling data pin.
        cycle(1'b1, 1'b0, 1'b0, 1'b0);
        feed(64'h5, 3);
        saved = crc_o;
        for (int i = 0; i < 6; i++) cycle(1'b0, 1'b0, i[0], 1'b0);
        check("R4 hold when idle", crc_o, saved);

        // R2: clear wins over data and shift.
        cycle(1'b1, 1'b1, 1'b1, 1'b1);
        check("R2 clear priority", crc_o, 15'h0);

        // R7: shift wins over data.
        feed(64'h1, 1);  // crc = 0x4599
        cycle(1'b0, 1'b1, 1'b1, 1'b1);
        check("R7 shift ignores data", crc_o, 15'h0B32);

        // R6: serial readout of the known frame's check value.
        cycle(1'b1, 1'b0, 1'b0, 1'b0);
        feed(VECS[0].bits, 47);
        got = '0;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            shift_i = 1'b1;
            #1 got = {got[13:0], ser_o};
            @(negedge clk);
            shift_i = 1'b0;
        end
        check("R6 serial MSB first", got, 15'h4A99);
        check("R6 empty after shifts", crc_o, 15'h0);

        // R3: reset in mid-frame.
        feed(64'h3, 2);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R3 reset clears", crc_o, 15'h0);
        rst_n = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule